// File: doc/BRIEF.md
# Non-Destructive Checkerboard Memory Tester

This block walks a synchronous single-port RAM from its lowest to its highest word and checks every word in place without losing what it held. For each word the controller first reads the word and parks it in a holding register. It then writes an alternating-bit pattern, reads it back and compares it. It does the same with the bitwise complement of that pattern. When both read-backs match, it writes the parked value back and moves on to the next address.

On the first read-back that does not match, the controller stops at once. It reports the address of that word, raises a fault flag and signals completion. That word is not written back, so it keeps the last pattern written to it. When every word passes, completion is signalled with the fault flag low. Either way the controller then waits for the next start pulse.

The memory is expected to return read data one cycle after the address is applied. A write is expected to be visible to a read issued in the following cycle.

Top module: `nd_ram_tester`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `fail` and `mem_we` are all low.
- R2: A `start` pulse sampled while idle begins a pass at address 0, and `busy` is high in the cycle after that edge. A `start` sampled while a pass is running, or in the `done` cycle, has no effect on the run or its timing.
- R3: Words are tested one at a time in strictly ascending address order, each exactly once. `mem_addr` never goes above DEPTH-1.
- R4: After a passing run, every RAM word holds the value it had before the start pulse.
- R5: Each passing word gets exactly three writes, in this order: pattern A, whose bit i is 1 when i is even (0x55 for 8 bits); then pattern B, which is the complement of A (0xAA); then the word's original value.
- R6: A passing word takes 9 cycles. In a fully passing run, `done` is high after the 9*DEPTH-th rising edge that follows the edge that sampled `start`.
- R7: On the first read-back mismatch the controller stops and raises `done` with `fail` high, and `fail_addr` gives that word's address. It makes no further write, and the failing word keeps the pattern last written to it. For word k, `done` follows 9k+5 edges after the start edge when pattern A mismatches, and 9k+8 edges when pattern B mismatches.
- R8: When every word passes, `done` is raised with `fail` low.
- R9: `fail` and `fail_addr` hold their values after `done` until the next accepted `start`, which clears `fail`.
- R10: `done` is a single-cycle pulse, and `busy` is low in the `done` cycle. `mem_we` is only ever high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a pass (honoured only when idle) |
| busy | output | 1 | High while a pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| fail | output | 1 | Set when a word failed its read-back; held until the next start |
| fail_addr | output | ADDR_W | Address of the first failing word |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after the address |

## Verification
The test step or the holding register may be corrupted. If the holding register captures the wrong cycle, the third write to a word carries a stale value, so a bench watching the write stream sees it at that word. The RAM image after the run also shows the damage. If the step sequence skips or repeats a state, the `done` cycle moves away from 9 cycles per word, and a skipped or repeated address appears in the per-word write counts. A comparator that selects the wrong pattern flags a healthy word at word 0, within the first nine cycles. A fault placed on pattern A or pattern B at a known word pins both the stop cycle and the reported address.

// File: rtl/ndt_pkg.sv
package ndt_pkg;

  // One state per RAM cycle of the per-word test.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAVE_RD,
    ST_SAVE_CAP,
    ST_WR_A,
    ST_RD_A,
    ST_CMP_A,
    ST_WR_B,
    ST_RD_B,
    ST_CMP_B,
    ST_RESTORE,
    ST_FINISH
  } ndt_state_e;

  // Source selector for the RAM write data.
  typedef enum logic [1:0] {
    WSRC_PAT_A,
    WSRC_PAT_B,
    WSRC_SAVED
  } ndt_wsrc_e;

  localparam int unsigned CYCLES_PER_WORD = 9;

  // Cycles from the start edge to done for a run in which every word passes.
  function automatic int unsigned pass_cycles(input int unsigned depth);
    return depth * CYCLES_PER_WORD;
  endfunction

  // Cycles from the start edge to done when word idx fails on pattern A or B.
  function automatic int unsigned fail_cycles(input int unsigned idx, input logic on_b);
    return idx * CYCLES_PER_WORD + (on_b ? 32'd8 : 32'd5);
  endfunction

endpackage

// File: rtl/ndt_pattern.sv
module ndt_pattern #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic              sel_b,
  output logic [DATA_W-1:0] pat_a,
  output logic [DATA_W-1:0] pat_b,
  output logic              mismatch
);

  // Alternating word: even bits set when not inverted, odd bits set otherwise.
  function automatic logic [DATA_W-1:0] checker_word(input logic inverted);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) begin
      w[i] = (i[0] == inverted);
    end
    return w;
  endfunction

  logic [DATA_W-1:0] expect_w;
  logic [DATA_W-1:0] diff;

  assign pat_a    = checker_word(1'b0);
  assign pat_b    = checker_word(1'b1);
  assign expect_w = sel_b ? pat_b : pat_a;

  for (genvar g = 0; g < DATA_W; g++) begin : g_cmp
    assign diff[g] = rdata[g] ^ expect_w[g];
  end

  assign mismatch = |diff;

endmodule

// File: rtl/ndt_addr_walker.sv
module ndt_addr_walker #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (clear) begin
      addr <= '0;
    end else if (step) begin
      addr <= addr + 1'b1;
    end
  end

  assign last = (addr == LAST_ADDR);

  AST_NO_STEP_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !last); // R3

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    addr <= LAST_ADDR); // R3

endmodule

// File: rtl/ndt_seq.sv
module ndt_seq
  import ndt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      last,
  input  logic      mismatch,
  output logic      clr,
  output logic      step,
  output logic      we,
  output ndt_wsrc_e wsrc,
  output logic      capture,
  output logic      chk,
  output logic      chk_b,
  output logic      busy,
  output logic      done,
  output logic      fail_evt
);

  ndt_state_e state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt     = state;
    clr     = 1'b0;
    step    = 1'b0;
    we      = 1'b0;
    wsrc    = WSRC_PAT_A;
    capture = 1'b0;
    chk     = 1'b0;
    chk_b   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          clr = 1'b1;
          nxt = ST_SAVE_RD;
        end
      end
      ST_SAVE_RD:  nxt = ST_SAVE_CAP;
      ST_SAVE_CAP: begin
        capture = 1'b1;
        nxt     = ST_WR_A;
      end
      ST_WR_A: begin
        we   = 1'b1;
        wsrc = WSRC_PAT_A;
        nxt  = ST_RD_A;
      end
      ST_RD_A: nxt = ST_CMP_A;
      ST_CMP_A: begin
        chk = 1'b1;
        nxt = mismatch ? ST_FINISH : ST_WR_B;
      end
      ST_WR_B: begin
        we   = 1'b1;
        wsrc = WSRC_PAT_B;
        nxt  = ST_RD_B;
      end
      ST_RD_B: nxt = ST_CMP_B;
      ST_CMP_B: begin
        chk   = 1'b1;
        chk_b = 1'b1;
        nxt   = mismatch ? ST_FINISH : ST_RESTORE;
      end
      ST_RESTORE: begin
        we   = 1'b1;
        wsrc = WSRC_SAVED;
        if (last) begin
          nxt = ST_FINISH;
        end else begin
          step = 1'b1;
          nxt  = ST_SAVE_RD;
        end
      end
      ST_FINISH: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign fail_evt = chk && mismatch;
  assign done     = (state == ST_FINISH);
  assign busy     = (state != ST_IDLE) && (state != ST_FINISH);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_STOP_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> done); // R7

  AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> busy); // R10

endmodule

// File: rtl/nd_ram_tester.sv
module nd_ram_tester
  import ndt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              clr, step, capture, chk, chk_b, fail_evt, last, mismatch;
  ndt_wsrc_e         wsrc;
  logic [DATA_W-1:0] pat_a, pat_b, saved;

  ndt_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .last     (last),
    .mismatch (mismatch),
    .clr      (clr),
    .step     (step),
    .we       (mem_we),
    .wsrc     (wsrc),
    .capture  (capture),
    .chk      (chk),
    .chk_b    (chk_b),
    .busy     (busy),
    .done     (done),
    .fail_evt (fail_evt)
  );

  ndt_addr_walker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clr),
    .step  (step),
    .addr  (mem_addr),
    .last  (last)
  );

  ndt_pattern #(.DATA_W(DATA_W)) u_pat (
    .rdata    (mem_rdata),
    .sel_b    (chk_b),
    .pat_a    (pat_a),
    .pat_b    (pat_b),
    .mismatch (mismatch)
  );

  // Holding register for the word under test.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       saved <= '0;
    else if (capture) saved <= mem_rdata;
  end

  // Fault flag and first failing address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_addr <= '0;
    end else if (clr) begin
      fail <= 1'b0;
    end else if (fail_evt) begin
      fail      <= 1'b1;
      fail_addr <= mem_addr;
    end
  end

  always_comb begin
    unique case (wsrc)
      WSRC_PAT_A: mem_wdata = pat_a;
      WSRC_PAT_B: mem_wdata = pat_b;
      WSRC_SAVED: mem_wdata = saved;
      default:    mem_wdata = saved;
    endcase
  end

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we); // R10

  AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mem_addr != $past(mem_addr)))
      |-> (mem_addr == $past(mem_addr) + 1'b1)); // R3

  AST_NO_WRITE_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> !mem_we); // R7

  AST_FAIL_RISES_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done); // R7

  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clr) |=> $stable(fail)); // R9

endmodule

// File: tb/nd_ram_tester_test.sv
`timescale 1ns/1ps
module nd_ram_tester_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam logic [DW-1:0] PA = {DW/2{2'b01}};
  localparam logic [DW-1:0] PB = {DW/2{2'b10}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, fail, mem_we;
  logic [AW-1:0] fail_addr, mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  nd_ram_tester #(.ADDR_W(AW), .DEPTH(DEPTH), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // RAM model with an optional stuck-bit fault on reads.
  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] snap [DEPTH];
  logic [DW-1:0] wlog [DEPTH][4];
  int            wcnt [DEPTH];
  int            order_err = 0;
  int            last_wa = 0;
  logic          clr_log = 1'b0;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic          f_en = 1'b0;
  logic [AW-1:0] f_addr = '0;
  logic [DW-1:0] f_mask = '0, f_val = '0;

  always @(posedge clk) begin
    if (clr_log) begin
      for (int i = 0; i < DEPTH; i++) wcnt[i] = 0;
      order_err = 0;
      last_wa = 0;
    end
    if (ld_en) ram[ld_addr] = ld_data;
    if (mem_we) begin
      if (int'(mem_addr) < last_wa) order_err++;
      last_wa = int'(mem_addr);
      if (wcnt[mem_addr] < 4) wlog[mem_addr][wcnt[mem_addr]] = mem_wdata;
      wcnt[mem_addr]++;
    end
    if (f_en && mem_addr == f_addr)
      mem_rdata <= (ram[mem_addr] & ~f_mask) | (f_val & f_mask);
    else
      mem_rdata <= ram[mem_addr];
    if (mem_we) ram[mem_addr] = mem_wdata;
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int mode);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      ld_en = 1'b1;
      ld_addr = AW'(a);
      case (mode)
        0: ld_data = DW'(a * 37 + 11);
        1: ld_data = PA;
        2: ld_data = PB;
        default: ld_data = DW'(255 - a);
      endcase
      snap[a] = ld_data;
    end
    @(negedge clk);
    ld_en = 1'b0;
    clr_log = 1'b1;
    @(negedge clk);
    clr_log = 1'b0;
  endtask

  // Runs one pass; mid_start pulses start after that many edges (0 = never).
  task automatic run(input int mid_start, output int edges, output int busy_bad);
    edges = 0;
    busy_bad = 0;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    while (1) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      start = (edges == mid_start);
      if (done) break;
      if (!busy) busy_bad++;
      if (edges > 2000) break;
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done in reset", int'({busy, done}), 0);
    check(fail === 1'b0 && mem_we === 1'b0, "R1 fail/we in reset", int'({fail, mem_we}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && fail === 1'b0 && mem_we === 1'b0,
          "R1 after reset", int'({busy, done, fail, mem_we}), 0);
  endtask

  task automatic t_pass(input int mode, input int mid_start);
    int edges, bb, seq_bad, cnt_bad, img_bad;
    fill(mode);
    run(mid_start, edges, bb);
    check(edges == DEPTH * 9, "R6 pass cycles", edges, DEPTH * 9);
    check(done === 1'b1 && fail === 1'b0, "R8 done with fail low", int'({done, fail}), 2);
    check(busy === 1'b0 && bb == 0, "R10 busy during run, low at done", bb, 0);
    @(negedge clk);
    check(done === 1'b0, "R10 done is one cycle", int'(done), 0);
    seq_bad = 0; cnt_bad = 0; img_bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      if (wcnt[a] != 3) cnt_bad++;
      else if (wlog[a][0] != PA || wlog[a][1] != PB || wlog[a][2] != snap[a]) seq_bad++;
      if (ram[a] != snap[a]) img_bad++;
    end
    check(cnt_bad == 0 && order_err == 0, "R3 one visit per word, ascending", cnt_bad + order_err, 0);
    check(seq_bad == 0, "R5 write sequence A, B, original", seq_bad, 0);
    check(img_bad == 0, "R4 contents restored", img_bad, 0);
    if (mid_start != 0)
      check(edges == DEPTH * 9 && img_bad == 0, "R2 start while busy ignored", edges, DEPTH * 9);
  endtask

  task automatic t_fault(input int k, input logic [DW-1:0] mask, input logic [DW-1:0] val,
                         input bit on_b);
    int edges, bb, below_bad, above_bad, exp_e;
    fill(0);
    @(negedge clk);
    f_en = 1'b1; f_addr = AW'(k); f_mask = mask; f_val = val;
    run(0, edges, bb);
    exp_e = k * 9 + (on_b ? 8 : 5);
    check(edges == exp_e, "R7 stop cycle", edges, exp_e);
    check(done === 1'b1 && fail === 1'b1, "R7 done with fail", int'({done, fail}), 3);
    check(fail_addr == AW'(k), "R7 fail address", int'(fail_addr), k);
    check(wcnt[k] == (on_b ? 2 : 1), "R7 no restore write", wcnt[k], on_b ? 2 : 1);
    check(ram[k] == (on_b ? PB : PA), "R7 failing word keeps pattern", int'(ram[k]),
          int'(on_b ? PB : PA));
    below_bad = 0; above_bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      if (a < k && ram[a] != snap[a]) below_bad++;
      if (a > k && (wcnt[a] != 0 || ram[a] != snap[a])) above_bad++;
    end
    check(below_bad == 0, "R4 earlier words restored", below_bad, 0);
    check(above_bad == 0, "R7 later words untouched", above_bad, 0);
    // start during the done cycle must be ignored
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(busy === 1'b0, "R2 start in done cycle ignored", int'(busy), 0);
    repeat (5) @(negedge clk);
    check(fail === 1'b1 && fail_addr == AW'(k), "R9 fail held", int'(fail), 1);
    f_en = 1'b0;
  endtask

  initial begin
    #(150000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) begin ram[a] = '0; wcnt[a] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    t_pass(0, 0);
    t_pass(1, 0);
    t_pass(2, 40);
    t_fault(5, 8'h02, 8'h02, 1'b0);   // stuck-at-1 bit1: A mismatch
    t_pass(3, 0);
    check(fail === 1'b0, "R9 new start clears fail", int'(fail), 0);
    t_fault(12, 8'h01, 8'h01, 1'b1);  // stuck-at-1 bit0: B mismatch
    t_fault(0, 8'h80, 8'h00, 1'b1);   // stuck-at-0 bit7: B mismatch
    t_fault(15, 8'h40, 8'h00, 1'b0);  // stuck-at-0 bit6: A mismatch
    t_pass(0, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule